// File: doc/BRIEF.md
# Conversion Result Post-Processing Comparator Bank

This block holds a bank of identical post-processing units that sit behind an analog-to-digital converter's sequencer. Each completed conversion arrives as a one-cycle pulse that carries the number of the conversion slot that produced it and the raw unsigned sample. Every unit is programmed with one slot number and handles only the conversions from that slot.

For a matching conversion, a unit does four things:
- It adds a signed calibration offset to the sample and clamps the sum to the converter's range.
- It subtracts a reference value, with optional negation, to form a signed 32-bit result.
- It compares the result against a high and a low limit, and checks for a change of sign from the unit's previous result.
- It records how many clock cycles have passed since the unit's previous conversion.

Each unit owns a 4-bit field in the shared event-select, interrupt-enable, clear and status vectors. The detected events latch into sticky status bits, and a per-unit interrupt line reports the status bits that are enabled. A per-unit option lets each new conversion replace the stored status instead of adding to it, so software does not have to clear the bits itself.

Top module: `ppb_cluster`

## Requirements
- R1: A unit processes a conversion only when `conv_valid` is high and `conv_slot` equals the unit's slot field. Its result, status and timestamp do not change for conversions from other slots. Unit n uses bits [n*SLOT_W +: SLOT_W] of `cfg_slot`.
- R2: The raw sample plus the sign-extended calibration offset is clamped to the range 0 to 2^RAW_W-1 before any further use.
- R3: The result is the clamped sample minus the unsigned reference when the negate bit is 0, and the reference minus the clamped sample when it is 1. The result appears on `ppb_result` one clock edge after the conversion pulse.
- R4: Event bit 0 (high trip) fires when the result is strictly greater than the high limit. Each limit is a two's-complement number of LIM_W+1 bits whose top bit is the separate sign input and whose lower bits are the magnitude field.
- R5: Event bit 1 (low trip) fires when the result is strictly less than the low limit, which is encoded in the same way as the high limit.
- R6: Event bit 2 (zero crossing) fires when the sign of the new result differs from the sign of the unit's previous result. A result of zero counts as non-negative, and the previous sign after reset is non-negative.
- R7: A detected event sets its status bit only when the matching bit of the unit's 4-bit field in `evt_sel` is 1.
- R8: Status bits are sticky and clear only when a 1 is written to the matching `evt_clr` bit. An event set in the same cycle as its clear wins over the clear. Bit 3 of every field always reads 0.
- R9: When a unit's `cfg_cbc` bit is 1, each processed conversion replaces that unit's whole status field with the events of that conversion.
- R10: `irq[n]` is high exactly when some bit of unit n's status field is 1 and the same bit of its `evt_ie` field is 1.
- R11: On each processed conversion, `stamp` takes the number of clock edges since the unit's previous processed conversion, saturating at 2^TS_W-1.
- R12: Reset (active low) clears all results, status bits, interrupt lines and timestamps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle conversion-complete pulse |
| conv_slot | input | SLOT_W | Slot number of the completed conversion |
| conv_data | input | RAW_W | Raw unsigned conversion sample |
| cfg_slot | input | NUM_UNITS*SLOT_W | Slot number that each unit follows |
| cfg_cal | input | NUM_UNITS*CAL_W | Signed calibration offset per unit |
| cfg_ref | input | NUM_UNITS*REF_W | Unsigned reference value per unit |
| cfg_negate | input | NUM_UNITS | Negate the result (reference minus sample) |
| cfg_cbc | input | NUM_UNITS | Status replaced on each conversion |
| cfg_hi_mag | input | NUM_UNITS*LIM_W | High limit magnitude field |
| cfg_hi_sgn | input | NUM_UNITS | High limit sign bit |
| cfg_lo_mag | input | NUM_UNITS*LIM_W | Low limit magnitude field |
| cfg_lo_sgn | input | NUM_UNITS | Low limit sign bit |
| evt_sel | input | NUM_UNITS*4 | Event latch enables, 4 bits per unit |
| evt_ie | input | NUM_UNITS*4 | Interrupt enables, 4 bits per unit |
| evt_clr | input | NUM_UNITS*4 | Write-one-to-clear pulses, 4 bits per unit |
| ppb_result | output | NUM_UNITS*32 | Signed processed result per unit |
| evt_stat | output | NUM_UNITS*4 | Sticky event status, 4 bits per unit |
| irq | output | NUM_UNITS | Interrupt request per unit |
| stamp | output | NUM_UNITS*TS_W | Cycles between consecutive conversions per unit |

## Verification
The bench builds the block with four units, 16 slots, 12-bit samples, 10-bit calibration and 16-bit reference and limits. These are the default values, so both the clamp at 4095 and the sign-extended negative limits are exercised at their real sizes. It narrows TS_W to 4, which makes timestamp saturation at 15 reachable after a few dozen idle cycles. Four units on distinct slots let one conversion be checked for its effect on the matching unit and for the absence of any effect on the other three.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int RES_W = 32;
  localparam int EVT_W = 4;
  localparam int EV_HI = 0;
  localparam int EV_LO = 1;
  localparam int EV_ZC = 2;

  // Add the calibration offset and clamp to [0, top].
  function automatic logic signed [31:0] clamp_cal(input logic signed [31:0] raw,
                                                  input logic signed [31:0] cal,
                                                  input logic signed [31:0] top);
    logic signed [31:0] s;
    s = raw + cal;
    if (s < 0) return 32'sd0;
    if (s > top) return top;
    return s;
  endfunction

  // Signed difference against the reference, optionally negated.
  function automatic logic signed [31:0] diff_ref(input logic signed [31:0] adj,
                                                 input logic signed [31:0] refv,
                                                 input logic neg);
    return neg ? (refv - adj) : (adj - refv);
  endfunction

  // Limit value: sign bit sits just above the magnitude field.
  function automatic logic signed [31:0] limit_val(input logic [31:0] mag,
                                                  input int unsigned mw,
                                                  input logic sgn);
    logic signed [31:0] m;
    m = $signed(mag);
    return sgn ? (m - (32'sd1 <<< mw)) : m;
  endfunction
endpackage

// File: rtl/ppb_calc.sv
module ppb_calc
  import ppb_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int CAL_W = 10,
  parameter int REF_W = 16,
  parameter int LIM_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit,
  input  logic [RAW_W-1:0]        raw,
  input  logic [CAL_W-1:0]        cal,
  input  logic [REF_W-1:0]        refv,
  input  logic                    negate,
  input  logic [LIM_W-1:0]        hi_mag,
  input  logic                    hi_sgn,
  input  logic [LIM_W-1:0]        lo_mag,
  input  logic                    lo_sgn,
  output logic signed [RES_W-1:0] result,
  output logic [EVT_W-1:0]        ev_new
);
  localparam logic signed [31:0] RAW_TOP = (32'sd1 <<< RAW_W) - 32'sd1;

  logic signed [31:0] adj, res_new, hi_lim, lo_lim, cal_ext;
  logic               prev_neg, new_neg;

  always_comb begin
    cal_ext = {{(32-CAL_W){cal[CAL_W-1]}}, cal};
    adj     = clamp_cal($signed(32'(raw)), cal_ext, RAW_TOP);
    res_new = diff_ref(adj, $signed(32'(refv)), negate);
    hi_lim  = limit_val(32'(hi_mag), LIM_W, hi_sgn);
    lo_lim  = limit_val(32'(lo_mag), LIM_W, lo_sgn);
    new_neg = res_new[31];
    ev_new        = '0;
    ev_new[EV_HI] = res_new > hi_lim;
    ev_new[EV_LO] = res_new < lo_lim;
    ev_new[EV_ZC] = new_neg ^ prev_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      prev_neg <= 1'b0;
    end else if (hit) begin
      result   <= res_new;
      prev_neg <= new_neg;
    end
  end
endmodule

// File: rtl/ppb_evt_flags.sv
module ppb_evt_flags #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             cbc,
  input  logic [EVT_W-1:0] ev_new,
  input  logic [EVT_W-1:0] sel,
  input  logic [EVT_W-1:0] clr,
  output logic [EVT_W-1:0] stat
);
  logic [EVT_W-1:0] base, nxt;

  always_comb begin
    base = (hit && cbc) ? '0 : stat;
    nxt  = (base & ~clr) | (hit ? (ev_new & sel) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= nxt;
  end
endmodule

// File: rtl/ppb_delay_stamp.sv
module ppb_delay_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  output logic [TS_W-1:0] stamp
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic [TS_W-1:0] cnt, inc;

  always_comb inc = (cnt == TS_MAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      stamp <= '0;
    end else if (hit) begin
      cnt   <= '0;
      stamp <= inc;
    end else begin
      cnt   <= inc;
    end
  end
endmodule

// File: rtl/ppb_cluster.sv
module ppb_cluster
  import ppb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int NUM_SLOTS = 16,
  parameter int RAW_W     = 12,
  parameter int CAL_W     = 10,
  parameter int REF_W     = 16,
  parameter int LIM_W     = 16,
  parameter int TS_W      = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         conv_valid,
  input  logic [SLOT_W-1:0]            conv_slot,
  input  logic [RAW_W-1:0]             conv_data,
  input  logic [NUM_UNITS*SLOT_W-1:0]  cfg_slot,
  input  logic [NUM_UNITS*CAL_W-1:0]   cfg_cal,
  input  logic [NUM_UNITS*REF_W-1:0]   cfg_ref,
  input  logic [NUM_UNITS-1:0]         cfg_negate,
  input  logic [NUM_UNITS-1:0]         cfg_cbc,
  input  logic [NUM_UNITS*LIM_W-1:0]   cfg_hi_mag,
  input  logic [NUM_UNITS-1:0]         cfg_hi_sgn,
  input  logic [NUM_UNITS*LIM_W-1:0]   cfg_lo_mag,
  input  logic [NUM_UNITS-1:0]         cfg_lo_sgn,
  input  logic [NUM_UNITS*EVT_W-1:0]   evt_sel,
  input  logic [NUM_UNITS*EVT_W-1:0]   evt_ie,
  input  logic [NUM_UNITS*EVT_W-1:0]   evt_clr,
  output logic [NUM_UNITS*RES_W-1:0]   ppb_result,
  output logic [NUM_UNITS*EVT_W-1:0]   evt_stat,
  output logic [NUM_UNITS-1:0]         irq,
  output logic [NUM_UNITS*TS_W-1:0]    stamp
);
  // Named per-unit events, visible to the bound checker.
  logic [NUM_UNITS-1:0] unit_hit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [EVT_W-1:0] ev_new;

    assign unit_hit[u] = conv_valid && (conv_slot == cfg_slot[u*SLOT_W +: SLOT_W]);

    ppb_calc #(
      .RAW_W(RAW_W), .CAL_W(CAL_W), .REF_W(REF_W), .LIM_W(LIM_W)
    ) u_calc (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (unit_hit[u]),
      .raw    (conv_data),
      .cal    (cfg_cal[u*CAL_W +: CAL_W]),
      .refv   (cfg_ref[u*REF_W +: REF_W]),
      .negate (cfg_negate[u]),
      .hi_mag (cfg_hi_mag[u*LIM_W +: LIM_W]),
      .hi_sgn (cfg_hi_sgn[u]),
      .lo_mag (cfg_lo_mag[u*LIM_W +: LIM_W]),
      .lo_sgn (cfg_lo_sgn[u]),
      .result (ppb_result[u*RES_W +: RES_W]),
      .ev_new (ev_new)
    );

    ppb_evt_flags #(.EVT_W(EVT_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (unit_hit[u]),
      .cbc    (cfg_cbc[u]),
      .ev_new (ev_new),
      .sel    (evt_sel[u*EVT_W +: EVT_W]),
      .clr    (evt_clr[u*EVT_W +: EVT_W]),
      .stat   (evt_stat[u*EVT_W +: EVT_W])
    );

    ppb_delay_stamp #(.TS_W(TS_W)) u_stamp (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (unit_hit[u]),
      .stamp (stamp[u*TS_W +: TS_W])
    );

    assign irq[u] = |(evt_stat[u*EVT_W +: EVT_W] & evt_ie[u*EVT_W +: EVT_W]);
  end
endmodule

// File: rtl/ppb_cluster_chk.sv
module ppb_cluster_chk #(
  parameter int NUM_UNITS = 4,
  parameter int TS_W      = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_UNITS-1:0]   unit_hit,
  input logic [NUM_UNITS*4-1:0] evt_clr,
  input logic [NUM_UNITS*4-1:0] evt_stat,
  input logic [NUM_UNITS*32-1:0] ppb_result,
  input logic [NUM_UNITS*TS_W-1:0] stamp,
  input logic [NUM_UNITS-1:0]   irq
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    // R1
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_hit[u] |=> $stable(ppb_result[u*32 +: 32]));
    // R11
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_hit[u] |=> $stable(stamp[u*TS_W +: TS_W]));
    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[u] |-> (evt_stat[u*4 +: 4] != 4'd0));
    for (genvar b = 0; b < 4; b++) begin : g_b
      // R8
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stat[u*4+b] && !unit_hit[u] && !evt_clr[u*4+b]) |=> evt_stat[u*4+b]);
      // R8
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr[u*4+b] && !unit_hit[u]) |=> !evt_stat[u*4+b]);
    end
  end
endmodule

bind ppb_cluster ppb_cluster_chk #(.NUM_UNITS(NUM_UNITS), .TS_W(TS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .unit_hit   (unit_hit),
  .evt_clr    (evt_clr),
  .evt_stat   (evt_stat),
  .ppb_result (ppb_result),
  .stamp      (stamp),
  .irq        (irq)
);

// File: tb/sim_ppb_cluster.sv
`timescale 1ns/1ps
module sim_ppb_cluster;
  localparam int NU = 4;
  localparam int TSW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              conv_valid = 1'b0;
  logic [3:0]        conv_slot = '0;
  logic [11:0]       conv_data = '0;
  logic [NU*4-1:0]   cfg_slot;
  logic [NU*10-1:0]  cfg_cal;
  logic [NU*16-1:0]  cfg_ref;
  logic [NU-1:0]     cfg_negate, cfg_cbc, cfg_hi_sgn, cfg_lo_sgn;
  logic [NU*16-1:0]  cfg_hi_mag, cfg_lo_mag;
  logic [NU*4-1:0]   evt_sel, evt_ie;
  logic [NU*4-1:0]   evt_clr = '0;
  logic [NU*32-1:0]  ppb_result;
  logic [NU*4-1:0]   evt_stat;
  logic [NU-1:0]     irq;
  logic [NU*TSW-1:0] stamp;

  ppb_cluster #(.NUM_UNITS(NU), .TS_W(TSW)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_slot(conv_slot),
    .conv_data(conv_data), .cfg_slot(cfg_slot), .cfg_cal(cfg_cal), .cfg_ref(cfg_ref),
    .cfg_negate(cfg_negate), .cfg_cbc(cfg_cbc), .cfg_hi_mag(cfg_hi_mag),
    .cfg_hi_sgn(cfg_hi_sgn), .cfg_lo_mag(cfg_lo_mag), .cfg_lo_sgn(cfg_lo_sgn),
    .evt_sel(evt_sel), .evt_ie(evt_ie), .evt_clr(evt_clr),
    .ppb_result(ppb_result), .evt_stat(evt_stat), .irq(irq), .stamp(stamp)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-side configuration and model
  int        slot_i[NU], cal_i[NU], ref_i[NU], hi_i[NU], lo_i[NU];
  bit        neg_b[NU], cbc_b[NU], hi_s[NU], lo_s[NU];
  logic [3:0] sel_v[NU], ie_v[NU];
  int        exp_res[NU];
  logic [3:0] exp_stat[NU];
  bit        prev_neg[NU];

  task automatic apply_cfg();
    for (int u = 0; u < NU; u++) begin
      cfg_slot[u*4 +: 4]    = slot_i[u][3:0];
      cfg_cal[u*10 +: 10]   = cal_i[u][9:0];
      cfg_ref[u*16 +: 16]   = ref_i[u][15:0];
      cfg_hi_mag[u*16 +: 16] = hi_i[u][15:0];
      cfg_lo_mag[u*16 +: 16] = lo_i[u][15:0];
      cfg_negate[u] = neg_b[u];
      cfg_cbc[u]    = cbc_b[u];
      cfg_hi_sgn[u] = hi_s[u];
      cfg_lo_sgn[u] = lo_s[u];
      evt_sel[u*4 +: 4] = sel_v[u];
      evt_ie[u*4 +: 4]  = ie_v[u];
    end
  endtask

  function automatic int model_res(int u, int data);
    int v;
    v = data + cal_i[u];
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return neg_b[u] ? (ref_i[u] - v) : (v - ref_i[u]);
  endfunction

  function automatic int lim(int mag, bit s);
    return s ? mag - 65536 : mag;
  endfunction

  task automatic chk(string req, string what, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_all(string req);
    for (int u = 0; u < NU; u++) begin
      chk(req, $sformatf("unit%0d result", u), $signed(ppb_result[u*32 +: 32]), exp_res[u]);
      chk(req, $sformatf("unit%0d status", u), evt_stat[u*4 +: 4], exp_stat[u]);
      chk(req, $sformatf("unit%0d irq", u), irq[u], |(exp_stat[u] & ie_v[u]));
    end
  endtask

  // Conversion pulse, optionally with a simultaneous clear; starts at a negedge.
  task automatic conv(string req, int slot, int data, logic [NU*4-1:0] clrv = '0);
    conv_valid = 1'b1;
    conv_slot  = slot[3:0];
    conv_data  = data[11:0];
    evt_clr    = clrv;
    for (int u = 0; u < NU; u++) begin
      logic [3:0] base, ev;
      int r;
      if (slot == slot_i[u]) begin
        r = model_res(u, data);
        ev = 4'b0000;
        ev[0] = r > lim(hi_i[u], hi_s[u]);
        ev[1] = r < lim(lo_i[u], lo_s[u]);
        ev[2] = (r < 0) != prev_neg[u];
        base = cbc_b[u] ? 4'b0000 : exp_stat[u];
        exp_stat[u] = (base & ~clrv[u*4 +: 4]) | (ev & sel_v[u]);
        prev_neg[u] = (r < 0);
        exp_res[u] = r;
      end else begin
        exp_stat[u] = exp_stat[u] & ~clrv[u*4 +: 4];
      end
    end
    @(posedge clk);
    @(negedge clk);
    conv_valid = 1'b0;
    evt_clr    = '0;
    check_all(req);
  endtask

  task automatic clear(string req, logic [NU*4-1:0] m);
    evt_clr = m;
    for (int u = 0; u < NU; u++) exp_stat[u] = exp_stat[u] & ~m[u*4 +: 4];
    @(posedge clk);
    @(negedge clk);
    evt_clr = '0;
    check_all(req);
  endtask

  task automatic t_reset();
    for (int u = 0; u < NU; u++) begin
      chk("R12", "reset result", ppb_result[u*32 +: 32], 0);
      chk("R12", "reset status", evt_stat[u*4 +: 4], 0);
      chk("R12", "reset stamp", stamp[u*TSW +: TSW], 0);
    end
    chk("R12", "reset irq", irq, 0);
  endtask

  task automatic t_slot();
    conv("R1", 3, 100);
    chk("R1", "unit0 result", $signed(ppb_result[31:0]), 100);
    chk("R1", "unit1 untouched", ppb_result[63:32], 0);
    conv("R1", 11, 50);
    chk("R1", "unmatched slot", $signed(ppb_result[31:0]), 100);
  endtask

  task automatic t_cal();
    cal_i[0] = -50; apply_cfg();
    conv("R2", 3, 30);
    chk("R2", "clamp low", $signed(ppb_result[31:0]), 0);
    cal_i[0] = 200; apply_cfg();
    conv("R2", 3, 4000);
    chk("R2", "clamp high", $signed(ppb_result[31:0]), 4095);
    cal_i[0] = 25; apply_cfg();
    conv("R2", 3, 100);
    chk("R2", "offset add", $signed(ppb_result[31:0]), 125);
    cal_i[0] = 0; apply_cfg();
  endtask

  task automatic t_ref();
    ref_i[0] = 1000; apply_cfg();
    conv("R3", 3, 400);
    chk("R3", "sample minus ref", $signed(ppb_result[31:0]), -600);
    neg_b[0] = 1'b1; apply_cfg();
    conv("R3", 3, 400);
    chk("R3", "negated", $signed(ppb_result[31:0]), 600);
    neg_b[0] = 1'b0; ref_i[0] = 0; apply_cfg();
  endtask

  task automatic t_trip();
    clear("R8", {NU{4'hF}});
    conv("R4", 3, 500);
    chk("R4", "equal to high limit", evt_stat[0], 0);
    conv("R4", 3, 501);
    chk("R4", "above high limit", evt_stat[0], 1);
    clear("R8", {NU{4'hF}});
    ref_i[0] = 100; apply_cfg();
    conv("R5", 3, 0);
    chk("R5", "equal to low limit", evt_stat[1], 0);
    ref_i[0] = 101; apply_cfg();
    conv("R5", 3, 0);
    chk("R5", "below low limit", evt_stat[1], 1);
    ref_i[0] = 0; apply_cfg();
  endtask

  task automatic t_sel();
    sel_v[1] = 4'b0110; apply_cfg();
    conv("R7", 5, 900);
    chk("R7", "masked high trip", evt_stat[4], 0);
  endtask

  task automatic t_zc();
    conv("R6", 7, 10);
    chk("R6", "no sign change", evt_stat[10], 0);
    ref_i[2] = 50; apply_cfg();
    conv("R6", 7, 10);
    chk("R6", "to negative", evt_stat[10], 1);
    clear("R8", 16'h0400);
    conv("R6", 7, 20);
    chk("R6", "stays negative", evt_stat[10], 0);
    ref_i[2] = 0; apply_cfg();
    conv("R6", 7, 0);
    chk("R6", "zero is non-negative", evt_stat[10], 1);
  endtask

  task automatic t_clear();
    conv("R8", 3, 600);
    repeat (3) @(negedge clk);
    check_all("R8");
    conv("R8", 3, 700, 16'h0001);
    chk("R8", "set beats clear", evt_stat[0], 1);
    clear("R8", 16'h0001);
    chk("R8", "cleared", evt_stat[0], 0);
  endtask

  task automatic t_cbc();
    conv("R9", 9, 800);
    chk("R9", "high trip latched", evt_stat[12], 1);
    conv("R9", 9, 50);
    chk("R9", "replaced by new events", evt_stat[15:12], 0);
  endtask

  task automatic t_irq();
    ie_v[1] = 4'b0100; ref_i[1] = 1000; apply_cfg();
    conv("R10", 5, 0);
    chk("R10", "enabled zero-cross irq", irq[1], 1);
    ie_v[1] = 4'b1001; apply_cfg();
    #1;
    check_all("R10");
    chk("R10", "disabled bits no irq", irq[1], 0);
  endtask

  task automatic t_stamp();
    conv("R11", 7, 5);
    repeat (6) @(negedge clk);
    conv("R11", 7, 5);
    chk("R11", "interval", stamp[2*TSW +: TSW], 7);
    chk("R11", "other unit untouched", stamp[0 +: TSW] != 0, 1);
    repeat (30) @(negedge clk);
    conv("R11", 7, 5);
    chk("R11", "saturated", stamp[2*TSW +: TSW], 15);
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin
      slot_i[u] = 3 + 2*u + (u == 3 ? 0 : 0);
      cal_i[u] = 0; ref_i[u] = 0; neg_b[u] = 0; cbc_b[u] = (u == 3);
      hi_i[u] = 500; hi_s[u] = 0; lo_i[u] = 65436; lo_s[u] = 1;
      sel_v[u] = 4'hF; ie_v[u] = 4'h0;
      exp_res[u] = 0; exp_stat[u] = 4'h0; prev_neg[u] = 0;
    end
    apply_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slot();
    t_cal();
    t_ref();
    t_trip();
    t_sel();
    t_zc();
    t_clear();
    t_cbc();
    t_irq();
    t_stamp();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule